// File: doc/BRIEF.md
# Line-Delimited Stream Packetizer

This block merges several independent byte streams onto one output byte stream without mixing their contents. Each input stream delivers bytes on a data/valid pair, one byte per cycle at most. No back-pressure is possible on the inputs. Every stream has its own ring buffer. Incoming bytes wait there until a line-feed byte (0x0A) closes the line. Only then does the line become eligible for output. The output sends it as one packet: a header byte naming the source stream comes first, then the line's bytes in arrival order, ending with the line feed.

When a stream fills its buffer before the line ends, the partial line is thrown away. The write pointer moves back to where that line began, so completed lines already queued are unaffected. The stream then ignores input up to and including the next line feed. A per-stream counter records each dropped line. Streams with complete lines waiting are served in rotating order, one whole packet at a time. The output is a valid/ready stream that the downstream transmitter may stall at any cycle.

Top module: `line_packetizer`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0 and every drop counter reads 0.
- R2: No byte of a line appears on the output before that line's line feed (0x0A) has been accepted on its input.
- R3: Every packet begins with a header byte equal to 0x80 plus the stream number (0 to 3). The line's bytes follow in arrival order, and the line feed is the last byte of the packet.
- R4: Once a header has been sent, every byte up to and including the line feed comes from that same stream. Bytes of different streams are never interleaved.
- R5: When several streams have complete lines, the next packet is taken from the first waiting stream after the one served last, in increasing stream order with wrap-around. After reset, stream 0 is considered first.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R7: Each stream buffers at most 64 bytes. A byte arriving for a full buffer drops the line in progress, and the lines already completed in that buffer are still delivered intact.
- R8: After a drop, the stream discards input bytes up to and including the next line feed and buffers normally from the byte after it. If the byte that found the buffer full was itself a line feed, buffering resumes on the very next byte.
- R9: Each stream's drop counter, an 8-bit value that wraps, increases by exactly one per dropped line. Stream s occupies bits [8s+7:8s] of drop_count.
- R10: All streams accept a byte in the same cycle without loss, independently of each other and of the output state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 4 | Per-stream byte strobe, bit s for stream s |
| in_data | input | 32 | Per-stream byte, stream s on bits [8s+7:8s] |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the output byte this cycle |
| out_data | output | 8 | Output byte: header or line byte |
| drop_count | output | 32 | Per-stream dropped-line counters, 8 bits each |

## Verification
The embedded assertions check on every cycle the output hold under back-pressure and that each packet opens with a byte from the header range. They also check that at most one buffer is popped per cycle, that a buffer is only popped while it holds a completed line, that buffer occupancy never exceeds its capacity, and that a drop steps its counter by exactly one. The bench's scenarios are needed for the rest. These are the byte-exact content of each packet, that nothing leaves before its line feed, the rotating service order, the rollback that keeps earlier complete lines, and the discard window after a drop, including the case where the overflowing byte is the line feed itself. Expected streams, occupancies and drop counts come from a behavioural model in the bench, run over a sweep of line lengths sent concurrently on all four streams under steady and intermittent back-pressure.

// File: rtl/lp_pkg.sv
// Package: shared types for the line packetizer.
// Assumes: nothing beyond IEEE 1800-2017.
package lp_pkg;
    // Output sequencer states: waiting, sending header, sending line body
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_BODY = 2'd2
    } lp_state_e;
endpackage

// File: rtl/lp_lane.sv
// Module: lp_lane
// One stream's ring buffer. Bytes are written at the write pointer. A line
// becomes readable once its terminator is stored. If a byte arrives while the
// buffer is full, the line in progress is dropped: the write pointer returns to
// that line's start and input is ignored through the next terminator.
// Assumes: DEPTH is a power of two; the reader pops only while line_ready is
// high and stops after popping a terminator.
module lp_lane #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter logic [7:0] TERM = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              line_ready,
    output logic [CNT_W-1:0]  drop_cnt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL_LVL = (PTR_W+1)'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W:0]    wr_ptr, rd_ptr, pkt_start, used, line_cnt;
    logic              discarding;
    logic              is_term, full, accept, drop, commit, pop_term;

    // Decode this cycle's write, drop and pop events
    always_comb begin
        used     = wr_ptr - rd_ptr;
        full     = (used == FULL_LVL);
        is_term  = (in_data == DATA_W'(TERM));
        accept   = in_valid && !discarding && !full;
        drop     = in_valid && !discarding && full;
        commit   = accept && is_term;
        rd_data  = mem[rd_ptr[PTR_W-1:0]];
        pop_term = rd_en && (rd_data == DATA_W'(TERM));
        line_ready = (line_cnt != '0);
    end

    // Storage array write
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr[PTR_W-1:0]] <= in_data;
    end

    // Pointer, line count, discard state and drop counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            pkt_start  <= '0;
            line_cnt   <= '0;
            discarding <= 1'b0;
            drop_cnt   <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (drop)   wr_ptr <= pkt_start;
            if (commit) pkt_start <= wr_ptr + 1'b1;
            if (drop && !is_term)
                discarding <= 1'b1;
            else if (in_valid && discarding && is_term)
                discarding <= 1'b0;
            if (drop) drop_cnt <= drop_cnt + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            case ({commit, pop_term})
                2'b10:   line_cnt <= line_cnt + 1'b1;
                2'b01:   line_cnt <= line_cnt - 1'b1;
                default: line_cnt <= line_cnt;
            endcase
        end
    end

    // R7: occupancy never passes capacity
    a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        used <= FULL_LVL);
    // R2: reads only happen while a completed line is stored
    a_r2_pop_committed: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> line_cnt != '0);
    // R9: one drop moves the counter by exactly one
    a_r9_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> drop_cnt == $past(drop_cnt) + 1'b1);
endmodule

// File: rtl/lp_rr_arb.sv
// Module: lp_rr_arb
// Round-robin pick: returns the first requesting index after `last`,
// wrapping around. Pure combinational.
// Assumes: N >= 2.
module lp_rr_arb #(
    parameter int N = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             any,
    output logic [IDX_W-1:0] pick
);
    // Scan from farthest to nearest so the nearest requester wins
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = N; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (req[idx]) begin
                any  = 1'b1;
                pick = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/line_packetizer.sv
// Module: line_packetizer
// Top level: one ring-buffer lane per input stream, a round-robin pick among
// lanes with complete lines, and a sequencer that sends header then line body
// on a valid/ready output.
// Assumes: inputs cannot be stalled; downstream may hold out_ready low freely.
module line_packetizer
    import lp_pkg::*;
#(
    parameter int N_STREAMS = 4,
    parameter int DEPTH     = 64,
    parameter int CNT_W     = 8,
    parameter logic [7:0] TERM     = 8'h0A,
    parameter logic [7:0] HDR_BASE = 8'h80
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_STREAMS-1:0]   in_valid,
    input  logic [N_STREAMS*8-1:0] in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [7:0]             out_data,
    output logic [N_STREAMS*CNT_W-1:0] drop_count
);
    localparam int IDX_W = $clog2(N_STREAMS);

    lp_state_e            state;
    logic [IDX_W-1:0]     sel, last, pick;
    logic                 any;
    logic [N_STREAMS-1:0] ready_vec, rd_en;
    logic [7:0]           lane_data [N_STREAMS];
    logic                 out_fire;

    // One buffer lane per stream
    for (genvar s = 0; s < N_STREAMS; s++) begin : g_lane
        assign rd_en[s] = (state == ST_BODY) && out_ready && (sel == IDX_W'(s));
        lp_lane #(.DEPTH(DEPTH), .DATA_W(8), .CNT_W(CNT_W), .TERM(TERM)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[s]),
            .in_data   (in_data[s*8 +: 8]),
            .rd_en     (rd_en[s]),
            .rd_data   (lane_data[s]),
            .line_ready(ready_vec[s]),
            .drop_cnt  (drop_count[s*CNT_W +: CNT_W])
        );
    end

    lp_rr_arb #(.N(N_STREAMS)) u_arb (
        .req (ready_vec),
        .last(last),
        .any (any),
        .pick(pick)
    );

    // Output byte and valid from the sequencer state
    always_comb begin
        out_valid = (state != ST_IDLE);
        case (state)
            ST_HDR:  out_data = HDR_BASE + 8'(sel);
            ST_BODY: out_data = lane_data[sel];
            default: out_data = '0;
        endcase
        out_fire = out_valid && out_ready;
    end

    // Sequencer: choose a lane, send header, stream body through terminator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= '0;
            last  <= IDX_W'(N_STREAMS - 1);
        end else begin
            case (state)
                ST_IDLE: if (any) begin
                    sel   <= pick;
                    state <= ST_HDR;
                end
                ST_HDR: if (out_fire) state <= ST_BODY;
                ST_BODY: if (out_fire && out_data == TERM) begin
                    last  <= sel;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a stalled output byte stays put
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R3: a packet always opens with a header-range byte
    a_r3_header_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data >= HDR_BASE) &&
                             (out_data < HDR_BASE + 8'(N_STREAMS)));
    // R4: at most one lane is drained at a time
    a_r4_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_en));
endmodule

// File: tb/sim_line_packetizer.sv
module sim_line_packetizer;
    localparam int NS = 4;
    localparam int DEPTH = 64;
    localparam logic [7:0] LF = 8'h0A;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  in_valid = '0;
    logic [31:0] in_data = '0;
    logic        out_valid, out_ready;
    logic [7:0]  out_data;
    logic [31:0] drop_count;

    int checks = 0, failures = 0;
    int ready_mode = 0;
    int cyc = 0;

    // model state
    logic [7:0] exp_q [NS][1024];
    int qw [NS], qr [NS];
    logic [7:0] pend [NS][DEPTH];
    int plen [NS], occ [NS], drops [NS];
    bit disc [NS];
    int cur = -1, pkt_len = 0;
    int rr_log [64];
    int rr_n = 0;

    line_packetizer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .drop_count(drop_count)
    );

    always #5 clk = ~clk;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model of one byte arriving on stream s
    task automatic model_byte(int s, logic [7:0] b);
        if (disc[s]) begin
            if (b == LF) disc[s] = 0;
        end else if (occ[s] == DEPTH) begin
            occ[s] -= plen[s];
            plen[s] = 0;
            drops[s]++;
            if (b != LF) disc[s] = 1;
        end else begin
            pend[s][plen[s]] = b;
            plen[s]++;
            occ[s]++;
            if (b == LF) begin
                for (int i = 0; i < plen[s]; i++) begin
                    exp_q[s][qw[s] % 1024] = pend[s][i];
                    qw[s]++;
                end
                plen[s] = 0;
            end
        end
    endtask

    task automatic drive(logic [3:0] v, logic [31:0] d);
        @(posedge clk); #2;
        in_valid = v;
        in_data  = d;
        for (int s = 0; s < NS; s++) if (v[s]) model_byte(s, d[s*8 +: 8]);
    endtask

    task automatic idle_in();
        @(posedge clk); #2;
        in_valid = '0;
    endtask

    task automatic send(int s, logic [7:0] b);
        drive(4'(1 << s), 32'(b) << (8 * s));
    endtask

    task automatic drain();
        int t = 0;
        bit busy = 1;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
            busy = (cur >= 0) || out_valid;
            for (int s = 0; s < NS; s++) if (qr[s] != qw[s]) busy = 1;
        end
        chk(!busy, "R3 drain complete", t, 0);
    endtask

    // output ready pattern
    always @(posedge clk) begin
        #2;
        cyc++;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = ((cyc * 5) % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    // output monitor (R3, R4 byte checks)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (cur < 0) begin
                int h;
                h = int'(out_data) - 8'h80;
                chk(h >= 0 && h < NS && qr[h] < qw[h], "R3 header", out_data, 8'h80);
                if (h >= 0 && h < NS) cur = h;
                if (rr_n < 64) begin rr_log[rr_n] = h; rr_n++; end
                pkt_len = 0;
            end else begin
                logic [7:0] e;
                e = exp_q[cur][qr[cur] % 1024];
                chk(out_data == e, "R4 body byte", out_data, e);
                qr[cur]++;
                pkt_len++;
                if (out_data == LF) begin
                    occ[cur] -= pkt_len;
                    cur = -1;
                end
            end
        end
    end

    task automatic chk_drops(string req);
        for (int s = 0; s < NS; s++)
            chk(drop_count[s*8 +: 8] == 8'(drops[s]), req, drop_count[s*8 +: 8], drops[s]);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin
            qw[s] = 0; qr[s] = 0; plen[s] = 0; occ[s] = 0; drops[s] = 0; disc[s] = 0;
        end
        out_ready = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
        chk(drop_count == 0, "R1 drop counters in reset", drop_count, 0);
        @(posedge clk); #2; rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        chk(drop_count == 0, "R1 drop counters after reset", drop_count, 0);

        // R2: partial line stays inside
        for (int i = 0; i < 5; i++) send(3, 8'h61 + 8'(i));
        idle_in();
        repeat (20) @(negedge clk);
        chk(out_valid == 0, "R2 no output before line feed", out_valid, 0);
        send(3, LF);
        idle_in();
        drain();

        // R5: one line in every stream, released together; last served = 3
        ready_mode = 2;
        for (int i = 0; i < 3; i++) drive(4'hF, (i == 2) ? {4{LF}} : 32'h31323334);
        idle_in();
        repeat (10) @(posedge clk);
        rr_n = 0;
        ready_mode = 0;
        drain();
        for (int i = 0; i < 4; i++) chk(rr_log[i] == i, "R5 order from stream 0", rr_log[i], i);
        // R5: two lines each on streams 0 and 2, last served = 3
        ready_mode = 2;
        for (int k = 0; k < 2; k++) begin
            drive(4'b0101, 32'h00470046);
            drive(4'b0101, {8'h0, LF, 8'h0, LF});
        end
        idle_in();
        repeat (10) @(posedge clk);
        rr_n = 0;
        ready_mode = 0;
        drain();
        chk(rr_log[0] == 0, "R5 rotation", rr_log[0], 0);
        chk(rr_log[1] == 2, "R5 rotation", rr_log[1], 2);
        chk(rr_log[2] == 0, "R5 rotation", rr_log[2], 0);
        chk(rr_log[3] == 2, "R5 rotation", rr_log[3], 2);

        // R10 sweep: all streams at once, varied lengths, steady and stalled output (R6)
        for (int rep = 0; rep < 24; rep++) begin
            int len [NS];
            int mx = 0;
            ready_mode = rep % 2;
            for (int s = 0; s < NS; s++) begin
                len[s] = 1 + ((rep * 3 + s * 5) % 9);
                if (len[s] > mx) mx = len[s];
            end
            for (int i = 0; i < mx; i++) begin
                logic [3:0] v = '0;
                logic [31:0] d = '0;
                for (int s = 0; s < NS; s++) if (i < len[s]) begin
                    v[s] = 1'b1;
                    d[s*8 +: 8] = (i == len[s] - 1) ? LF : 8'(8'h20 + (rep * 7 + s * 13 + i) % 90);
                end
                drive(v, d);
            end
            idle_in();
            drain();
        end
        chk_drops("R9 no drops in sweep");

        // R7/R8: overflow cases with output stalled
        ready_mode = 2;
        repeat (6) @(posedge clk);
        for (int i = 0; i < 70; i++) send(1, 8'h41 + 8'(i % 20));
        send(1, LF);
        send(1, 8'h78); send(1, 8'h79); send(1, LF);
        for (int i = 0; i < 9; i++) send(2, 8'h50 + 8'(i));
        send(2, LF);
        for (int i = 0; i < 60; i++) send(2, 8'h30 + 8'(i % 40));
        send(2, LF);
        send(2, 8'h7A); send(2, LF);
        for (int i = 0; i < 64; i++) send(0, 8'h21 + 8'(i % 50));
        send(0, LF);
        send(0, 8'h71); send(0, LF);
        idle_in();
        chk(drops[1] == 1 && drops[2] == 1 && drops[0] == 1, "R7 model drop tally", drops[1], 1);
        repeat (3) @(negedge clk);
        chk_drops("R9 counters after first drops");
        for (int i = 0; i < 70; i++) send(1, 8'h42);
        send(1, LF);
        send(1, 8'h79); send(1, LF);
        idle_in();
        repeat (3) @(negedge clk);
        chk(drop_count[15:8] == 8'd2, "R9 second drop on stream 1", drop_count[15:8], 2);
        chk_drops("R8 counters after discard window");
        ready_mode = 1;
        drain();
        chk_drops("R7 counters after drain");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule